// File: doc/BRIEF.md
# Programmable Watchdog With Steering

This block supervises a processor by timing the interval between proofs of life. Software programs a single 8-bit control register holding a timeout multiplier, a resolution code and a steering bit. The timeout is counted in strobes of a sub-second tick input, where one tick stands for 1/16 s. Writing the register, or any change of level on the kick input, starts the period over. When the period runs out, the block sets a watchdog flag. The steering bit then routes the event one of two ways. It either holds an active-low interrupt request, or it fires a fixed-width active-low reset pulse that also clears the register and strobes a clear to neighbouring control bits.

The control is a four-state machine. The states are `ST_IDLE` (not armed), `ST_RUN` (counting), `ST_IRQ_HOLD` (interrupt held) and `ST_RST_PULSE` (reset pulse in progress). The transitions are:
- arm: `ST_IDLE` to `ST_RUN` on a write with a nonzero multiplier.
- disarm: `ST_RUN` to `ST_IDLE` on a write with a zero multiplier.
- expire-to-interrupt: `ST_RUN` to `ST_IRQ_HOLD` on timeout with steering 0.
- expire-to-reset: `ST_RUN` to `ST_RST_PULSE` on timeout with steering 1.
- release: `ST_IRQ_HOLD` to `ST_IDLE` on a write of 0x00.
- pulse-done: `ST_RST_PULSE` to `ST_RUN` or `ST_IDLE` after the pulse, depending on whether the register was rewritten with a nonzero multiplier during the pulse.
- power-loss: any state to `ST_IDLE` on power fail.

Address decoding lives outside the block. The bus delivers a write strobe and a flags-read strobe. It holds the read strobe for as long as the address stays on the flags location.

Top module: `wdog_steer`

## Requirements
- R1: A write on `wr_en_i` loads `wr_data_i` into the register, which reads back on `wd_reg_o` from the next cycle. The fields are: bit 7 steering, bits 6:2 multiplier, bits 1:0 resolution.
- R2: The timeout is multiplier × resolution ticks, with resolution code 00 = 1 tick, 01 = 4, 10 = 16 and 11 = 64 ticks. The event is seen in the cycle after the tick that completes the count, and not one tick earlier.
- R3: A register with multiplier 0 (including 0x00) disarms the watchdog, and no number of ticks produces a timeout.
- R4: A register write, or a rising or falling edge of `kick_i` (passed through a two-flop synchroniser), restarts the full period.
- R5: With steering 0, a timeout drives `irq_n_o` low. It stays low through kicks and nonzero writes and is released only by a write of 0x00.
- R6: A timeout sets `wd_flag_o`. The flag clears only when `flag_rd_i` is held high for at least 2 consecutive cycles, and a 1-cycle strobe leaves it set.
- R7: With steering 1, a timeout drives `wd_rst_n_o` low for exactly `RST_CYCLES` clock cycles, and `irq_n_o` stays high.
- R8: A steering-1 timeout clears the register to 0x00 and asserts `ctl_clr_o` for exactly one cycle, the first cycle of the reset pulse.
- R9: `pwr_fail_i` clears the register to 0x00 and returns the block to the disarmed state.
- R10: After reset, `irq_n_o` and `wd_rst_n_o` are high, `wd_flag_o` and `ctl_clr_o` are low, and the register is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe, one per 1/16 s |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| kick_i | input | 1 | Asynchronous kick level; either edge restarts the period |
| flag_rd_i | input | 1 | Flags-read strobe, held while the address is stable |
| pwr_fail_i | input | 1 | Power-down indication |
| irq_n_o | output | 1 | Active-low interrupt request |
| wd_rst_n_o | output | 1 | Active-low reset pulse |
| wd_flag_o | output | 1 | Watchdog flag |
| ctl_clr_o | output | 1 | One-cycle clear strobe for frequency-test and alarm-enable bits |
| wd_reg_o | output | 8 | Current register contents |

## Verification
The bench walks every resolution code and multipliers from 1 to 31. It checks one tick before and one tick after the expected expiry, so a counter off by one, or a swapped resolution code, fires early or late and is caught. Directed cases cover the following:
- A kick and a rewrite in mid-period. A design that ignored either edge of the kick would expire early.
- A nonzero write while the interrupt is held. A design that released the interrupt on any write would raise `irq_n_o` too soon.
- A 1-cycle flags read. A design without the hold qualifier would lose the flag.
- The width of the reset pulse and the clearing of the register in that pulse.
- A multiplier of zero with a nonzero resolution code, and power loss in mid-period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_IRQ_HOLD,
        ST_RST_PULSE
    } wd_state_e;

endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic edge_o
);

    logic [SYNC_STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[SYNC_STAGES-1:0], kick_i};
        end
    end

    // either level change after synchronisation counts as a kick
    assign edge_o = pipe_q[SYNC_STAGES] ^ pipe_q[SYNC_STAGES-1];

endmodule

// File: rtl/wdog_period.sv
module wdog_period #(
    parameter int MULT_W    = 5,
    parameter int STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              clr_i,
    input  logic              tick_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic [1:0]        res_i,
    output logic              expire_o
);

    localparam int CNT_W = MULT_W + 3 * STEP_LOG2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] limit_m1;

    // each resolution code step multiplies the tick count by 2**STEP_LOG2
    assign limit    = CNT_W'(mult_i) << (int'(res_i) * STEP_LOG2);
    assign limit_m1 = limit - CNT_W'(1);
    assign expire_o = en_i && tick_i && !clr_i && (cnt_q == limit_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || !en_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= expire_o ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R2: while counting, the tick count never reaches the programmed limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (cnt_q < limit));

endmodule

// File: rtl/wdog_flag.sv
module wdog_flag #(
    parameter int RD_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    output logic flag_o
);

    localparam int HC_W = $clog2(RD_HOLD + 1);

    logic [HC_W-1:0] hold_q;
    logic            clr;

    assign clr = rd_i && (hold_q == HC_W'(RD_HOLD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (!rd_i) begin
            hold_q <= '0;
        end else if (hold_q != HC_W'(RD_HOLD)) begin
            hold_q <= hold_q + HC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr) begin
            flag_o <= 1'b0;
        end
    end

    // R6: the flag only drops after a read strobe
    p_flag_clear_by_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(rd_i));

    // R6: a new timeout always leaves the flag set
    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
    import wdog_pkg::*;
#(
    parameter int MULT_W     = 5,
    parameter int STEP_LOG2  = 2,
    parameter int RST_CYCLES = 16,
    parameter int RD_HOLD    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic                   wr_en_i,
    input  logic [MULT_W+2:0]      wr_data_i,
    input  logic                   kick_i,
    input  logic                   flag_rd_i,
    input  logic                   pwr_fail_i,
    output logic                   irq_n_o,
    output logic                   wd_rst_n_o,
    output logic                   wd_flag_o,
    output logic                   ctl_clr_o,
    output logic [MULT_W+2:0]      wd_reg_o
);

    localparam int REG_W = MULT_W + 3;
    localparam int PC_W  = $clog2(RST_CYCLES + 1);

    wd_state_e        state_q, state_d;
    logic [REG_W-1:0] reg_q;
    logic [PC_W-1:0]  pcnt_q;

    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [1:0]        res;
    logic              wr_arms;
    logic              wr_zero;
    logic              kick_edge;
    logic              restart;
    logic              expire;
    logic              pulse_done;

    assign steer      = reg_q[REG_W-1];
    assign mult       = reg_q[REG_W-2:2];
    assign res        = reg_q[1:0];
    assign wr_arms    = (wr_data_i[REG_W-2:2] != '0);
    assign wr_zero    = (wr_data_i == '0);
    assign restart    = wr_en_i || kick_edge;
    assign pulse_done = (pcnt_q == PC_W'(RST_CYCLES - 1));

    wdog_kick_sync #(.SYNC_STAGES(2)) u_kick (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick_i (kick_i),
        .edge_o (kick_edge)
    );

    wdog_period #(.MULT_W(MULT_W), .STEP_LOG2(STEP_LOG2)) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (state_q == ST_RUN),
        .clr_i    (restart),
        .tick_i   (tick_i),
        .mult_i   (mult),
        .res_i    (res),
        .expire_o (expire)
    );

    wdog_flag #(.RD_HOLD(RD_HOLD)) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (expire),
        .rd_i   (flag_rd_i),
        .flag_o (wd_flag_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (pwr_fail_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_en_i && wr_arms) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (wr_en_i && !wr_arms) state_d = ST_IDLE;
                    else if (expire)         state_d = steer ? ST_RST_PULSE : ST_IRQ_HOLD;
                end
                ST_IRQ_HOLD: begin
                    if (wr_en_i && wr_zero) state_d = ST_IDLE;
                end
                ST_RST_PULSE: begin
                    if (pulse_done) state_d = (mult != '0) ? ST_RUN : ST_IDLE;
                end
            endcase
        end
    end

    // state register, control register and pulse counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            reg_q   <= '0;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (pwr_fail_i)            reg_q <= '0;
            else if (expire && steer)  reg_q <= '0;
            else if (wr_en_i)          reg_q <= wr_data_i;
            if (state_q == ST_RST_PULSE && !pwr_fail_i) pcnt_q <= pcnt_q + PC_W'(1);
            else                                        pcnt_q <= '0;
        end
    end

    // outputs decoded from state
    always_comb begin
        irq_n_o    = 1'b1;
        wd_rst_n_o = 1'b1;
        ctl_clr_o  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RUN: ;
            ST_IRQ_HOLD:  irq_n_o = 1'b0;
            ST_RST_PULSE: begin
                wd_rst_n_o = 1'b0;
                ctl_clr_o  = (pcnt_q == '0);
            end
        endcase
    end

    assign wd_reg_o = reg_q;

    // R5: only a zero write or power loss releases a held interrupt
    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o && !pwr_fail_i && !(wr_en_i && wr_zero)) |=> !irq_n_o);

    // R7: interrupt and reset pulse are never active together
    p_no_dual_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!irq_n_o && !wd_rst_n_o));

    // R7: pulse counter stays inside the programmed width
    p_pulse_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RST_PULSE) |-> (pcnt_q < PC_W'(RST_CYCLES)));

    // R8: a reset pulse starts with the register cleared and the clear strobe
    p_pulse_clears_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_n_o) |-> (wd_reg_o == '0 && ctl_clr_o));

    // R9: power loss empties the register and quiets both outputs
    p_pwr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail_i |=> (wd_reg_o == '0 && irq_n_o && wd_rst_n_o));

    // R6: an interrupt never appears without the flag
    p_flag_on_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> wd_flag_o);

endmodule

// File: tb/test_wdog_steer.sv
module test_wdog_steer;

    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 16;
    localparam int NVEC       = 8;

    // {register value, expected ticks to timeout}
    localparam logic [18:0] VEC [0:NVEC-1] = '{
        {8'h05, 11'd4},   {8'h0E, 11'd48}, {8'h04, 11'd1},  {8'h07, 11'd64},
        {8'h0A, 11'd32},  {8'h7C, 11'd31}, {8'h7D, 11'd124}, {8'h7F, 11'd1984}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       kick = 1'b0;
    logic       flag_rd = 1'b0;
    logic       pwr_fail = 1'b0;
    logic       irq_n, wd_rst_n, wd_flag, ctl_clr;
    logic [7:0] wd_reg;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdog_steer #(.MULT_W(5), .STEP_LOG2(2), .RST_CYCLES(RST_CYC), .RD_HOLD(2)) i_wdog_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .kick_i     (kick),
        .flag_rd_i  (flag_rd),
        .pwr_fail_i (pwr_fail),
        .irq_n_o    (irq_n),
        .wd_rst_n_o (wd_rst_n),
        .wd_flag_o  (wd_flag),
        .ctl_clr_o  (ctl_clr),
        .wd_reg_o   (wd_reg)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic do_kick();
        @(negedge clk) kick = ~kick;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_flags(input int n);
        @(negedge clk) flag_rd = 1'b1;
        repeat (n) @(negedge clk);
        flag_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int         n;
        int         low;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check(irq_n == 1'b1, "R10 irq_n", irq_n, 1);
        check(wd_rst_n == 1'b1, "R10 wd_rst_n", wd_rst_n, 1);
        check(wd_flag == 1'b0, "R10 flag", wd_flag, 0);
        check(ctl_clr == 1'b0, "R10 ctl_clr", ctl_clr, 0);
        check(wd_reg == 8'h00, "R10 reg", wd_reg, 0);

        // table of timeouts (R1, R2, R5, R6)
        for (int i = 0; i < NVEC; i++) begin
            d = VEC[i][18:11];
            n = int'(VEC[i][10:0]);
            wr(d);
            check(wd_reg == d, "R1 readback", wd_reg, d);
            ticks(n - 1);
            check(irq_n == 1'b1, "R2 not early", irq_n, 1);
            ticks(1);
            check(irq_n == 1'b0, "R2 on time", irq_n, 0);
            check(wd_flag == 1'b1, "R6 flag set", wd_flag, 1);
            wr(8'h00);
            check(irq_n == 1'b1, "R5 release by zero", irq_n, 1);
            rd_flags(2);
            @(negedge clk);
            check(wd_flag == 1'b0, "R6 flag cleared", wd_flag, 0);
        end

        // R4 kick restarts
        wr(8'h05);
        ticks(3);
        do_kick();
        ticks(3);
        check(irq_n == 1'b1, "R4 kick rise restarts", irq_n, 1);
        do_kick();
        ticks(3);
        check(irq_n == 1'b1, "R4 kick fall restarts", irq_n, 1);
        ticks(1);
        check(irq_n == 1'b0, "R4 expiry after kick", irq_n, 0);

        // R5 nonzero write and kick do not release
        wr(8'h05);
        do_kick();
        ticks(10);
        check(irq_n == 1'b0, "R5 held through write", irq_n, 0);

        // R6 short read keeps flag
        rd_flags(1);
        @(negedge clk);
        check(wd_flag == 1'b1, "R6 short read ignored", wd_flag, 1);
        wr(8'h00);
        check(irq_n == 1'b1, "R5 zero releases", irq_n, 1);
        rd_flags(2);
        @(negedge clk);
        check(wd_flag == 1'b0, "R6 long read clears", wd_flag, 0);

        // R4 rewrite restarts
        wr(8'h05);
        ticks(3);
        wr(8'h05);
        ticks(3);
        check(irq_n == 1'b1, "R4 rewrite restarts", irq_n, 1);
        ticks(1);
        check(irq_n == 1'b0, "R4 expiry after rewrite", irq_n, 0);
        wr(8'h00);

        // R7 R8 steered reset pulse
        wr(8'h85);
        ticks(3);
        check(wd_rst_n == 1'b1, "R7 pulse not early", wd_rst_n, 1);
        ticks(1);
        check(wd_rst_n == 1'b0, "R7 pulse starts", wd_rst_n, 0);
        check(irq_n == 1'b1, "R7 irq stays high", irq_n, 1);
        check(ctl_clr == 1'b1, "R8 clear strobe", ctl_clr, 1);
        check(wd_reg == 8'h00, "R8 register cleared", wd_reg, 0);
        low = 0;
        while (!wd_rst_n && low < 100) begin
            low++;
            @(negedge clk);
            if (low == 1) check(ctl_clr == 1'b0, "R8 strobe one cycle", ctl_clr, 0);
        end
        check(low == RST_CYC, "R7 pulse width", low, RST_CYC);
        ticks(70);
        check(wd_rst_n == 1'b1 && irq_n == 1'b1, "R8 disarmed after pulse", wd_rst_n, 1);
        rd_flags(2);

        // R3 zero multiplier with nonzero resolution
        wr(8'h83);
        ticks(100);
        check(irq_n == 1'b1 && wd_rst_n == 1'b1, "R3 no timeout", irq_n, 1);
        check(wd_flag == 1'b0, "R3 no flag", wd_flag, 0);

        // R9 power fail
        wr(8'h05);
        ticks(2);
        @(negedge clk) pwr_fail = 1'b1;
        @(negedge clk) pwr_fail = 1'b0;
        check(wd_reg == 8'h00, "R9 register cleared", wd_reg, 0);
        ticks(10);
        check(irq_n == 1'b1 && wd_flag == 1'b0, "R9 disarmed", irq_n, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule